// File: doc/BRIEF.md
# Serial Converter Interface with Pulse-Coded Power-Down

This block is the digital front end of a serial sampling converter. A rising edge on the conversion strobe captures the current sample word. The result then leaves on a single serial data line, clocked by an external serial clock. The line is modelled as a data bit plus an output enable. A frame is one status bit followed by the data word, most significant bit first. The line is released after the last bit. When no conversion is outstanding, the line stays undriven.

The same strobe also carries power commands. Strobe pulses sent while the serial clock is held low are counted, and the count selects a low-power state. Two pulses select a light nap. Four pulses select a deep sleep in which the reference is treated as unpowered. A rising serial clock edge clears the count and wakes the block. Waking from sleep passes through a forced nap until an internal settle counter marks the reference as ready. A conversion started while the block is napping returns an all-zero frame, so the receiver can read the power state from the status bit.

Both inputs are treated as synchronous to the system clock. Wake-up and settle delays are counted in system clock cycles.

Top module: `adc_serial_pm`

## Requirements
- R1: After reset the data enable is low, nap and sleep are low, and the reference-ready flag is high.
- R2: When a second strobe pulse falls while the serial clock is low, with no rising serial clock edge since the first pulse, nap goes high on the next system clock edge. The reference-ready flag stays high.
- R3: When the fourth such pulse falls, sleep goes high on the next system clock edge. At the same edge nap goes low and reference-ready goes low.
- R4: A rising serial clock edge clears the pulse count. Pulse counts of 1 or 3 leave nap and sleep unchanged.
- R5: A rising serial clock edge during nap keeps nap high for NAP_WAKE_CYC+1 system cycles after the edge is sampled, then clears it.
- R6: A rising serial clock edge during sleep clears sleep and raises nap, with reference-ready low. Exactly REF_SETTLE_CYC+1 system cycles later, reference-ready rises and nap falls on the same cycle.
- R7: After a conversion start, the serial clock edges output the frame. The first qualifying rising edge drives the status bit with the enable high. Each of the next 12 edges presents one data bit, MSB first. The following edge drops the enable. A status bit of 1 means the reference is ready.
- R8: A strobe rising edge while a frame is pending or being shifted is ignored. The running frame keeps its captured bits, and no second frame follows.
- R9: If the first rising serial clock edge comes less than SETUP_CYC system cycles after the strobe rising edge, that edge drives nothing. The frame starts one serial clock edge later.
- R10: A conversion started while nap or sleep is high outputs 13 zero bits with the enable high.
- R11: Serial clock edges with no conversion outstanding leave the enable low. A power-down command cancels a conversion that has not begun shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| conv | input | 1 | Conversion strobe and power command pulses |
| sample | input | DATA_W | Sample word captured at a conversion start |
| sdo | output | 1 | Serial data bit, valid while sdoEn is high |
| sdoEn | output | 1 | Serial line drive enable; low means high impedance |
| napOut | output | 1 | Nap state, including the forced nap after sleep |
| sleepOut | output | 1 | Sleep state |
| refReady | output | 1 | Reference settled, sent as the frame status bit |

## Verification
A serial clock rise is registered on the next system edge, and the line shows its new bit one system cycle after that. The monitor therefore samples two system cycles after each serial clock rise, while the clock is held high for several cycles. Nap and sleep change on the system edge that follows the falling strobe, so each is read just after that edge. The wake delays are checked on both sides of their boundary: once a few cycles before NAP_WAKE_CYC+1 or REF_SETTLE_CYC+1 runs out, and once a few cycles after. A late setup is produced by raising the serial clock one cycle after the strobe. The scoreboard then expects one undriven edge before the status bit.

// File: rtl/adc_serial_pm_pkg.sv
package adc_serial_pm_pkg;

  typedef enum logic [2:0] {
    PwrActive,
    PwrNap,
    PwrNapWake,
    PwrSleep,
    PwrRefWait
  } pwrState_t;

  typedef enum logic [1:0] {
    FrmIdle,
    FrmPend,
    FrmLate,
    FrmShift
  } frmState_t;

  typedef struct packed {
    logic load;
    logic statusBit;
    logic drive;
    logic shift;
    logic release_;
  } dpStrobe_t;

endpackage

// File: rtl/adc_serial_pm_ctrl.sv
module adc_serial_pm_ctrl
  import adc_serial_pm_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter int NAP_WAKE_CYC   = 6,
  parameter int REF_SETTLE_CYC = 40,
  parameter int SETUP_CYC      = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      conv,
  output dpStrobe_t strobe,
  output logic      napOut,
  output logic      sleepOut,
  output logic      refReady
);

  localparam int FRAME_LEN = DATA_W + 1;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int WAKE_MAX  = (NAP_WAKE_CYC > REF_SETTLE_CYC) ? NAP_WAKE_CYC : REF_SETTLE_CYC;
  localparam int WAKE_W    = $clog2(WAKE_MAX + 1);
  localparam int SETUP_W   = (SETUP_CYC < 1) ? 1 : $clog2(SETUP_CYC + 1);
  localparam int PULSE_W   = 3;

  // input edge detection
  logic sclkQ, convQ;
  logic sclkRise, convRise, convFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      convQ <= 1'b0;
    end else begin
      sclkQ <= sclk;
      convQ <= conv;
    end
  end

  assign sclkRise = sclk & ~sclkQ;
  assign convRise = conv & ~convQ;
  assign convFall = ~conv & convQ & ~sclk;

  // power command pulse counter
  logic [PULSE_W-1:0] pulseCnt, pulseNext;
  logic cmdNap, cmdSleep;

  assign pulseNext = pulseCnt + PULSE_W'(1);
  assign cmdNap    = convFall && (pulseNext == PULSE_W'(2));
  assign cmdSleep  = convFall && (pulseNext == PULSE_W'(4));

  always_ff @(posedge clk) begin
    if (!rstN)
      pulseCnt <= '0;
    else if (sclkRise)
      pulseCnt <= '0;
    else if (convFall && (pulseCnt != '1))
      pulseCnt <= pulseNext;
  end

  // power state machine
  pwrState_t pwrState;
  logic [WAKE_W-1:0] wakeCnt;
  logic goNap, goSleep, powerDown;

  assign goNap     = cmdNap && ((pwrState == PwrActive) || (pwrState == PwrNapWake));
  assign goSleep   = cmdSleep && (pwrState != PwrSleep);
  assign powerDown = goNap || goSleep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrState <= PwrActive;
      wakeCnt  <= '0;
    end else if (goSleep) begin
      pwrState <= PwrSleep;
    end else if (goNap) begin
      pwrState <= PwrNap;
    end else begin
      case (pwrState)
        PwrNap: if (sclkRise) begin
          pwrState <= PwrNapWake;
          wakeCnt  <= WAKE_W'(NAP_WAKE_CYC);
        end
        PwrSleep: if (sclkRise) begin
          pwrState <= PwrRefWait;
          wakeCnt  <= WAKE_W'(REF_SETTLE_CYC);
        end
        PwrNapWake, PwrRefWait: begin
          if (wakeCnt == '0) pwrState <= PwrActive;
          else wakeCnt <= wakeCnt - WAKE_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign napOut   = (pwrState == PwrNap) || (pwrState == PwrNapWake) || (pwrState == PwrRefWait);
  assign sleepOut = (pwrState == PwrSleep);
  assign refReady = (pwrState != PwrSleep) && (pwrState != PwrRefWait);

  // frame sequencing
  frmState_t frmState, frmNext;
  logic [BIT_W-1:0]   bitCnt;
  logic [SETUP_W-1:0] setupCnt;
  logic setupOk;

  assign setupOk = (setupCnt >= SETUP_W'(SETUP_CYC));

  always_comb begin
    strobe  = '0;
    frmNext = frmState;
    case (frmState)
      FrmIdle: if (convRise) begin
        strobe.load      = 1'b1;
        strobe.statusBit = (pwrState == PwrActive);
        frmNext          = FrmPend;
      end
      FrmPend: begin
        if (powerDown) frmNext = FrmIdle;
        else if (sclkRise) begin
          if (setupOk) begin
            strobe.drive = 1'b1;
            frmNext      = FrmShift;
          end else begin
            frmNext = FrmLate;
          end
        end
      end
      FrmLate: begin
        if (powerDown) frmNext = FrmIdle;
        else if (sclkRise) begin
          strobe.drive = 1'b1;
          frmNext      = FrmShift;
        end
      end
      FrmShift: if (sclkRise) begin
        if (bitCnt == BIT_W'(FRAME_LEN - 1)) begin
          strobe.release_ = 1'b1;
          frmNext         = FrmIdle;
        end else begin
          strobe.shift = 1'b1;
        end
      end
      default: frmNext = FrmIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmState <= FrmIdle;
      bitCnt   <= '0;
      setupCnt <= '0;
    end else begin
      frmState <= frmNext;
      if (strobe.drive) bitCnt <= '0;
      else if (strobe.shift) bitCnt <= bitCnt + BIT_W'(1);
      if (strobe.load) setupCnt <= '0;
      else if ((frmState == FrmPend) && !setupOk) setupCnt <= setupCnt + SETUP_W'(1);
    end
  end

  // R2 R3
  nap_sleep_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(napOut && sleepOut));

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOut) |-> $past(convFall));

  // R6
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepOut) |-> (napOut && !refReady));

  // R6
  ready_full_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refReady) |-> (!napOut && !sleepOut));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convRise && (frmState != FrmIdle)) |=> !$past(strobe.load));

endmodule

// File: rtl/adc_serial_pm_dp.sv
module adc_serial_pm_dp
  import adc_serial_pm_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdoEn
);

  localparam int FRAME_LEN = DATA_W + 1;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] shReg;
  logic                 enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      enQ   <= 1'b0;
    end else begin
      if (strobe.load)
        shReg <= strobe.statusBit ? {1'b1, sample} : '0;
      else if (strobe.shift)
        shReg <= {shReg[FRAME_LEN-2:0], 1'b0};
      if (strobe.drive) enQ <= 1'b1;
      else if (strobe.release_) enQ <= 1'b0;
    end
  end

  assign sdoEn = enQ;
  assign sdo   = enQ ? shReg[FRAME_LEN-1] : 1'b0;

  // checker counter of shifts within one driven frame
  logic [CNT_W-1:0] shiftCnt;
  always_ff @(posedge clk) begin
    if (!rstN) shiftCnt <= '0;
    else if (strobe.drive) shiftCnt <= '0;
    else if (strobe.shift) shiftCnt <= shiftCnt + CNT_W'(1);
  end

  // R7
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> (shiftCnt <= CNT_W'(DATA_W)));

  // R7
  shift_while_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> sdoEn);

  // R11
  no_load_while_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !strobe.load);

endmodule

// File: rtl/adc_serial_pm.sv
module adc_serial_pm
  import adc_serial_pm_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter int NAP_WAKE_CYC   = 6,
  parameter int REF_SETTLE_CYC = 40,
  parameter int SETUP_CYC      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              conv,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdoEn,
  output logic              napOut,
  output logic              sleepOut,
  output logic              refReady
);

  dpStrobe_t strobe;

  adc_serial_pm_ctrl #(
    .DATA_W(DATA_W),
    .NAP_WAKE_CYC(NAP_WAKE_CYC),
    .REF_SETTLE_CYC(REF_SETTLE_CYC),
    .SETUP_CYC(SETUP_CYC)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sclk(sclk),
    .conv(conv),
    .strobe(strobe),
    .napOut(napOut),
    .sleepOut(sleepOut),
    .refReady(refReady)
  );

  adc_serial_pm_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .sample(sample),
    .sdo(sdo),
    .sdoEn(sdoEn)
  );

endmodule

// File: tb/adc_serial_pm_bench.sv
module adc_serial_pm_bench;

  localparam int DATA_W = 12;
  localparam int NAP    = 6;
  localparam int REFC   = 40;
  localparam int SETUP  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic conv = 1'b0;
  logic [DATA_W-1:0] sample = '0;
  logic sdo, sdoEn, napOut, sleepOut, refReady;

  int checks = 0;
  int fails = 0;

  logic [1:0] expQ[$];
  string      reqQ[$];

  always #5 clk = ~clk;

  adc_serial_pm #(
    .DATA_W(DATA_W), .NAP_WAKE_CYC(NAP), .REF_SETTLE_CYC(REFC), .SETUP_CYC(SETUP)
  ) u_adc_serial_pm (
    .clk(clk), .rstN(rstN), .sclk(sclk), .conv(conv), .sample(sample),
    .sdo(sdo), .sdoEn(sdoEn), .napOut(napOut), .sleepOut(sleepOut), .refReady(refReady)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(logic en, logic b, string req);
    expQ.push_back({en, b});
    reqQ.push_back(req);
  endtask

  task automatic sclkPulse(logic en, logic b, string req);
    pushExp(en, b, req);
    @(negedge clk) sclk = 1'b1;
    tick(3);
    sclk = 1'b0;
    tick(3);
  endtask

  task automatic convPulse(logic [DATA_W-1:0] v);
    @(negedge clk);
    sample = v;
    conv = 1'b1;
    tick(2);
    conv = 1'b0;
    tick(3);
  endtask

  task automatic shiftFrame(logic [DATA_W-1:0] v, bit zero, bit busy, string req);
    sclkPulse(1'b1, zero ? 1'b0 : 1'b1, req);
    for (int i = DATA_W - 1; i >= 0; i--) begin
      sclkPulse(1'b1, zero ? 1'b0 : v[i], req);
      if (busy && (i == 8 || i == 7)) begin
        convPulse(~v);
        // R4 single pulse between serial clock edges keeps the mode
        check("R4", "nap after busy pulse", int'(napOut), 0);
      end
    end
    sclkPulse(1'b0, 1'b0, req);
    sclkPulse(1'b0, 1'b0, busy ? "R8" : "R11");
  endtask

  task automatic runFrame(logic [DATA_W-1:0] v, bit busy);
    convPulse(v);
    // R4 one pulse alone does not change the mode
    check("R4", "nap after one pulse", int'(napOut), 0);
    shiftFrame(v, 1'b0, busy, busy ? "R8" : "R7");
  endtask

  task automatic runLateFrame(logic [DATA_W-1:0] v);
    @(negedge clk);
    sample = v;
    conv = 1'b1;
    pushExp(1'b0, 1'b0, "R9");
    @(negedge clk);
    sclk = 1'b1;
    conv = 1'b0;
    tick(3);
    sclk = 1'b0;
    tick(3);
    shiftFrame(v, 1'b0, 1'b0, "R9");
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge sclk);
      repeat (2) @(posedge clk);
      #1;
      if (expQ.size() == 0) begin
        check("R11", "unexpected serial edge", 1, 0);
      end else begin
        logic [1:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(r, "sdoEn", int'(sdoEn), int'(e[1]));
        if (e[1]) check(r, "sdo", int'(sdo), int'(e[0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    check("R1", "sdoEn", int'(sdoEn), 0);
    check("R1", "nap", int'(napOut), 0);
    check("R1", "sleep", int'(sleepOut), 0);
    check("R1", "refReady", int'(refReady), 1);

    // R11 no conversion leaves the line released
    sclkPulse(1'b0, 1'b0, "R11");
    sclkPulse(1'b0, 1'b0, "R11");

    // R7 frames with several patterns
    runFrame(12'hA5C, 1'b0);
    runFrame(12'hFFF, 1'b0);
    runFrame(12'h001, 1'b0);

    // R8 busy strobes ignored
    runFrame(12'h3C6, 1'b1);

    // R9 late setup
    runLateFrame(12'h5A1);

    // R2 nap entry, pending conversion cancelled
    convPulse(12'h123);
    check("R2", "nap after first pulse", int'(napOut), 0);
    convPulse(12'h123);
    check("R2", "nap after second pulse", int'(napOut), 1);
    check("R2", "sleep after second pulse", int'(sleepOut), 0);
    check("R2", "refReady in nap", int'(refReady), 1);
    check("R11", "sdoEn after cancel", int'(sdoEn), 0);
    // R4 third pulse keeps nap; R10 it starts a zero frame
    convPulse(12'hFFF);
    check("R4", "nap after third pulse", int'(napOut), 1);
    check("R4", "sleep after third pulse", int'(sleepOut), 0);
    shiftFrame(12'hFFF, 1'b1, 1'b0, "R10");
    check("R5", "nap cleared after frame", int'(napOut), 0);

    // R5 nap wake timing
    convPulse(12'h0F0);
    convPulse(12'h0F0);
    check("R2", "nap again", int'(napOut), 1);
    pushExp(1'b0, 1'b0, "R11");
    @(negedge clk) sclk = 1'b1;
    tick(1);
    tick(5);
    check("R5", "nap before wake delay", int'(napOut), 1);
    tick(3);
    check("R5", "nap after wake delay", int'(napOut), 0);
    sclk = 1'b0;
    tick(3);

    // R3 sleep entry
    convPulse(12'h111);
    convPulse(12'h111);
    check("R3", "nap at pulse two", int'(napOut), 1);
    convPulse(12'h111);
    convPulse(12'h111);
    check("R3", "sleep at pulse four", int'(sleepOut), 1);
    check("R3", "nap at pulse four", int'(napOut), 0);
    check("R3", "refReady at pulse four", int'(refReady), 0);
    check("R11", "sdoEn in sleep", int'(sdoEn), 0);

    // R6 sleep wake through forced nap
    pushExp(1'b0, 1'b0, "R11");
    @(negedge clk) sclk = 1'b1;
    tick(1);
    check("R6", "sleep after wake edge", int'(sleepOut), 0);
    check("R6", "nap after wake edge", int'(napOut), 1);
    check("R6", "refReady after wake edge", int'(refReady), 0);
    tick(REFC - 3);
    check("R6", "nap while settling", int'(napOut), 1);
    check("R6", "refReady while settling", int'(refReady), 0);
    tick(6);
    check("R6", "nap once settled", int'(napOut), 0);
    check("R6", "refReady once settled", int'(refReady), 1);
    sclk = 1'b0;
    tick(3);

    // R7 normal frame after sleep recovery
    runFrame(12'h7E3, 1'b0);

    tick(4);
    check("R7", "scoreboard drained", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule